// File: doc/BRIEF.md
# Banked Shadow Register File

This block is the general-purpose register file of a processor core, replicated into several banks. A context number picks the active bank. The instruction pipeline reaches only the active bank, through two combinational read ports and one write port. A special-purpose register (SPR) window reaches every register of every bank as a flat array of scratch words. The SPR window has one read address and one write strobe.

A mode pin controls the context number. When the pin is low, the context number is held at zero, so bank 0 is the architectural register set and the other banks are plain scratch storage behind the SPR window. When the pin is high, each exception-entry pulse advances the context number by one. A fresh bank then becomes active without any register being spilled to memory. A constant output reports how many shadow sets exist.

All ports are plain level signals with no handshake. Reads are combinational and are never stalled. Writes take effect at the rising clock edge on which their strobe is high.

Top module: `banked_regfile`

## Requirements
- R1: After reset, `ctx_id` is 0. Register contents are not defined by reset.
- R2: While `switch_en` is low, `ctx_id` becomes 0 at the next edge and stays there, and `exc_entry` has no effect on it.
- R3: While `switch_en` is high, an `exc_entry` pulse advances `ctx_id` by one at the next edge, and the value wraps from 15 to 0. Without a pulse, `ctx_id` holds.
- R4: Pipeline port addresses are 5-bit register numbers within the active bank. Bank b register r is physical word b*32+r. A write with `wr_en` high stores `wr_data` at the clock edge into the bank given by `ctx_id` in that cycle.
- R5: On both pipeline read ports, register 0 reads as zero. A pipeline write to register 0 is discarded.
- R6: A pipeline read of the register that the pipeline write port targets in the same cycle returns `wr_data` combinationally. Register 0 is excluded.
- R7: SPR addresses 1024 to 1535 form the window, with flat index = address − 1024, bank = flat / 32 and register = flat mod 32. `spr_we` stores `spr_wdata` there at the edge. `spr_rdata` returns the stored word combinationally, without forwarding a same-cycle write.
- R8: An SPR address outside the window reads as zero, and a write to such an address changes no register.
- R9: Through the window, register 0 of any bank stores and returns its value normally. The window aliases the pipeline view, so bank 0 is what the pipeline sees while `ctx_id` is 0.
- R10: When an SPR write and a pipeline write hit the same physical register in one cycle, the SPR value is kept.
- R11: `cfg_nshadow` reports the number of shadow sets, which is the bank count minus one (15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the context number |
| switch_en | input | 1 | 1 = context number advances on exceptions, 0 = context number held at zero |
| exc_entry | input | 1 | One-cycle pulse at exception entry |
| ctx_id | output | 4 | Active bank number |
| cfg_nshadow | output | 4 | Number of shadow register sets |
| rd_a_addr | input | 5 | Pipeline read port A register number |
| rd_a_data | output | 32 | Pipeline read port A data |
| rd_b_addr | input | 5 | Pipeline read port B register number |
| rd_b_data | output | 32 | Pipeline read port B data |
| wr_en | input | 1 | Pipeline write strobe |
| wr_addr | input | 5 | Pipeline write register number |
| wr_data | input | 32 | Pipeline write data |
| spr_addr | input | 16 | SPR index used by both SPR read and SPR write |
| spr_we | input | 1 | SPR write strobe |
| spr_wdata | input | 32 | SPR write data |
| spr_rdata | output | 32 | SPR read data |

## Verification
The hardest case to reach is a collision: an SPR write and a pipeline write that hit the same physical word in one cycle while the context number is nonzero. Random addresses almost never line up this way. To reach it, the stimulus often aims the SPR address at the active bank's slot for the pipeline's write register, computed from the observed `ctx_id`. Directed cases also cover the context wrap from 15 to 0 and the addresses at both edges of the window.

// File: rtl/brf_pkg.sv
package brf_pkg;
  typedef enum logic {
    CTX_FIXED  = 1'b0,
    CTX_SWITCH = 1'b1
  } ctx_mode_e;
endpackage

// File: rtl/brf_ctx.sv
module brf_ctx #(
  parameter int NBANK = 16,
  localparam int CW = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          switch_en,
  input  logic          exc_entry,
  output logic [CW-1:0] ctx_id
);
  import brf_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(NBANK - 1);

  ctx_mode_e mode;
  assign mode = switch_en ? CTX_SWITCH : CTX_FIXED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_id <= '0;
    end else if (mode == CTX_FIXED) begin
      ctx_id <= '0;
    end else if (exc_entry) begin
      ctx_id <= (ctx_id == LAST) ? '0 : ctx_id + 1'b1;
    end
  end

  p_fixed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !switch_en |=> ctx_id == '0);
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_en && exc_entry && ctx_id != LAST) |=> ctx_id == $past(ctx_id) + 1'b1);
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_en && exc_entry && ctx_id == LAST) |=> ctx_id == '0);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (switch_en && !exc_entry) |=> $stable(ctx_id));
endmodule

// File: rtl/brf_spr_dec.sv
module brf_spr_dec #(
  parameter int SPR_AW   = 16,
  parameter int SPR_BASE = 1024,
  parameter int NBANK    = 16,
  parameter int NREG     = 32,
  localparam int FW = $clog2(NBANK * NREG)
) (
  input  logic [SPR_AW-1:0] spr_addr,
  output logic              hit,
  output logic [FW-1:0]     flat
);
  localparam logic [SPR_AW-1:0] BASE_V = SPR_AW'(SPR_BASE);
  localparam logic [SPR_AW:0]   SPAN_V = (SPR_AW + 1)'(NBANK * NREG);

  logic [SPR_AW-1:0] off;

  always_comb begin
    off  = spr_addr - BASE_V;
    hit  = (spr_addr >= BASE_V) && ({1'b0, off} < SPAN_V);
    flat = off[FW-1:0];
  end
endmodule

// File: rtl/brf_store.sv
module brf_store #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 512,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            p_we,
  input  logic [IW-1:0]   p_idx,
  input  logic [XLEN-1:0] p_wd,
  input  logic            s_we,
  input  logic [IW-1:0]   s_idx,
  input  logic [XLEN-1:0] s_wd,
  input  logic [IW-1:0]   ra_idx,
  output logic [XLEN-1:0] ra_q,
  input  logic [IW-1:0]   rb_idx,
  output logic [XLEN-1:0] rb_q,
  input  logic [IW-1:0]   rs_idx,
  output logic [XLEN-1:0] rs_q
);
  logic [XLEN-1:0] mem [DEPTH];

  // Later assignment wins: the SPR port overrides a colliding pipeline write.
  always_ff @(posedge clk) begin
    if (p_we) mem[p_idx] <= p_wd;
    if (s_we) mem[s_idx] <= s_wd;
  end

  assign ra_q = mem[ra_idx];
  assign rb_q = mem[rb_idx];
  assign rs_q = mem[rs_idx];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int XLEN     = 32,
  parameter int NBANK    = 16,
  parameter int NREG     = 32,
  parameter int SPR_AW   = 16,
  parameter int SPR_BASE = 1024,
  localparam int CW = $clog2(NBANK),
  localparam int RW = $clog2(NREG),
  localparam int PW = CW + RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              switch_en,
  input  logic              exc_entry,
  output logic [CW-1:0]     ctx_id,
  output logic [CW-1:0]     cfg_nshadow,
  input  logic [RW-1:0]     rd_a_addr,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [RW-1:0]     rd_b_addr,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic              wr_en,
  input  logic [RW-1:0]     wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [SPR_AW-1:0] spr_addr,
  input  logic              spr_we,
  input  logic [XLEN-1:0]   spr_wdata,
  output logic [XLEN-1:0]   spr_rdata
);
  assign cfg_nshadow = CW'(NBANK - 1);

  brf_ctx #(.NBANK(NBANK)) u_ctx (
    .clk(clk), .rst_n(rst_n), .switch_en(switch_en),
    .exc_entry(exc_entry), .ctx_id(ctx_id)
  );

  logic          spr_hit;
  logic [PW-1:0] spr_flat;

  brf_spr_dec #(
    .SPR_AW(SPR_AW), .SPR_BASE(SPR_BASE), .NBANK(NBANK), .NREG(NREG)
  ) u_dec (
    .spr_addr(spr_addr), .hit(spr_hit), .flat(spr_flat)
  );

  logic            pipe_we;
  logic [XLEN-1:0] raw_a, raw_b, raw_s;

  assign pipe_we = wr_en && (wr_addr != '0);

  brf_store #(.XLEN(XLEN), .DEPTH(NBANK * NREG)) u_store (
    .clk(clk),
    .p_we(pipe_we), .p_idx({ctx_id, wr_addr}), .p_wd(wr_data),
    .s_we(spr_we && spr_hit), .s_idx(spr_flat), .s_wd(spr_wdata),
    .ra_idx({ctx_id, rd_a_addr}), .ra_q(raw_a),
    .rb_idx({ctx_id, rd_b_addr}), .rb_q(raw_b),
    .rs_idx(spr_flat), .rs_q(raw_s)
  );

  // Pipeline read muxing: zero register, then same-cycle forwarding.
  function automatic logic [XLEN-1:0] pipe_view(input logic [RW-1:0] a,
                                                input logic [XLEN-1:0] stored);
    if (a == '0) return '0;
    if (pipe_we && wr_addr == a) return wr_data;
    return stored;
  endfunction

  assign rd_a_data = pipe_view(rd_a_addr, raw_a);
  assign rd_b_data = pipe_view(rd_b_addr, raw_b);
  assign spr_rdata = spr_hit ? raw_s : '0;

  p_zero_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_addr == '0 |-> rd_a_data == '0);
  p_zero_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_addr == '0 |-> rd_b_data == '0);
  p_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spr_addr < SPR_AW'(SPR_BASE)) |-> spr_rdata == '0);
  p_write_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_we && !(spr_we && spr_hit && spr_flat == {ctx_id, wr_addr}) && !exc_entry)
    |=> ((rd_a_addr == $past(wr_addr) && ctx_id == $past(ctx_id)
          && !(wr_en && wr_addr == rd_a_addr)) -> rd_a_data == $past(wr_data)));
  p_spr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_we && spr_we && spr_hit && spr_flat == {ctx_id, wr_addr})
    |=> ((spr_addr == $past(spr_addr) && !spr_we) -> spr_rdata == $past(spr_wdata)));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        switch_en = 1'b0, exc_entry = 1'b0;
  logic [3:0]  ctx_id, cfg_nshadow;
  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, spr_wdata = '0, spr_rdata;
  logic        wr_en = 1'b0, spr_we = 1'b0;
  logic [15:0] spr_addr = '0;

  always #4 clk = ~clk;

  banked_regfile uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] m [512];
  bit          vld [512];
  int          ctx_m = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [15:0] a);
    return a >= 16'd1024 && a < 16'd1536;
  endfunction

  // Returns 1 and the expected value when the result is defined.
  function automatic bit exp_pipe(input logic [4:0] a, output logic [31:0] v);
    if (a == 0) begin v = 0; return 1; end
    if (wr_en && wr_addr == a) begin v = wr_data; return 1; end
    v = m[ctx_m*32 + a];
    return vld[ctx_m*32 + a];
  endfunction

  function automatic bit exp_spr(output logic [31:0] v);
    if (!in_win(spr_addr)) begin v = 0; return 1; end
    v = m[spr_addr - 16'd1024];
    return vld[spr_addr - 16'd1024];
  endfunction

  // Inputs are already driven after a falling edge; check, clock, update model.
  task automatic step();
    logic [31:0] e;
    #1;
    check((ctx_m == 0) ? "R2 ctx" : "R3 ctx", {28'd0, ctx_id}, ctx_m);
    if (exp_pipe(rd_a_addr, e))
      check(rd_a_addr == 0 ? "R5 port A" : (wr_en && wr_addr == rd_a_addr) ? "R6 port A" : "R4 port A", rd_a_data, e);
    if (exp_pipe(rd_b_addr, e))
      check(rd_b_addr == 0 ? "R5 port B" : (wr_en && wr_addr == rd_b_addr) ? "R6 port B" : "R4 port B", rd_b_data, e);
    if (exp_spr(e))
      check(in_win(spr_addr) ? "R7 spr read" : "R8 spr read", spr_rdata, e);
    @(posedge clk);
    if (wr_en && wr_addr != 0) begin m[ctx_m*32 + wr_addr] = wr_data; vld[ctx_m*32 + wr_addr] = 1; end
    if (spr_we && in_win(spr_addr)) begin m[spr_addr - 16'd1024] = spr_wdata; vld[spr_addr - 16'd1024] = 1; end
    if (!switch_en) ctx_m = 0;
    else if (exc_entry) ctx_m = (ctx_m + 1) % 16;
    @(negedge clk);
    wr_en = 0; spr_we = 0; exc_entry = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset ctx", {28'd0, ctx_id}, 0);
    rst_n = 1;
    check("R11 shadow count", {28'd0, cfg_nshadow}, 15);
    @(negedge clk);

    // R7/R9: fill every word through the window, register 0 included.
    for (int i = 0; i < 512; i++) begin
      spr_addr = 16'(1024 + i); spr_we = 1; spr_wdata = 32'hA500_0000 + i;
      step();
    end
    spr_addr = 16'd1024; step();
    check("R9 bank0 reg0 via spr", spr_rdata, 32'hA500_0000);
    rd_a_addr = 5'd7; #1;
    check("R9 alias bank0", rd_a_data, 32'hA500_0007);
    rd_a_addr = 0; spr_addr = 16'd1535; #1;
    check("R7 last word", spr_rdata, 32'hA500_01FF);

    // R8: out-of-window writes leave neighbours intact.
    spr_addr = 16'd1023; spr_we = 1; spr_wdata = 32'hDEAD_0001; step();
    spr_addr = 16'd1536; spr_we = 1; spr_wdata = 32'hDEAD_0002; step();
    spr_addr = 16'hFFFF; spr_we = 1; spr_wdata = 32'hDEAD_0003; step();
    spr_addr = 16'd1023; #1; check("R8 below window", spr_rdata, 0);
    spr_addr = 16'd1024; #1; check("R8 first word intact", spr_rdata, 32'hA500_0000);
    spr_addr = 16'd1535; #1; check("R8 last word intact", spr_rdata, 32'hA500_01FF);

    // R5: pipeline write to register 0 is dropped.
    wr_en = 1; wr_addr = 0; wr_data = 32'h1234_5678; step();
    rd_a_addr = 0; spr_addr = 16'd1024; #1;
    check("R5 x0 reads zero", rd_a_data, 0);
    check("R5 x0 write dropped", spr_rdata, 32'hA500_0000);

    // R2: exceptions ignored in fixed mode.
    exc_entry = 1; step();
    #1; check("R2 exc ignored", {28'd0, ctx_id}, 0);

    // R3: full cycle of banks with wrap.
    switch_en = 1;
    for (int k = 1; k <= 16; k++) begin
      exc_entry = 1; step(); #1;
      check("R3 advance", {28'd0, ctx_id}, k % 16);
    end
    exc_entry = 1; step(); exc_entry = 1; step(); exc_entry = 1; step(); // ctx 3

    // R10: collision in bank 3.
    wr_en = 1; wr_addr = 5'd9; wr_data = 32'h0000_1111;
    spr_we = 1; spr_addr = 16'(1024 + 3*32 + 9); spr_wdata = 32'h0000_2222;
    step();
    #1; check("R10 spr wins", spr_rdata, 32'h0000_2222);
    rd_b_addr = 5'd9; #1; check("R10 pipeline view", rd_b_data, 32'h0000_2222);

    // Random phase.
    for (int n = 0; n < 6000; n++) begin
      int r;
      if (n % 1500 == 0) switch_en = (n % 3000 == 0);
      exc_entry = ($urandom_range(7) == 0);
      wr_en = $urandom_range(1); wr_addr = 5'($urandom_range(31)); wr_data = $urandom;
      rd_a_addr = ($urandom_range(3) == 0) ? wr_addr : 5'($urandom_range(31));
      rd_b_addr = 5'($urandom_range(31));
      r = $urandom_range(5);
      if (r < 2) spr_addr = 16'(1024 + ctx_m*32 + wr_addr);
      else if (r < 4) spr_addr = 16'(1024 + $urandom_range(511));
      else if (r == 4) spr_addr = 16'($urandom_range(1023));
      else spr_addr = 16'(1536 + $urandom_range(64000));
      spr_we = $urandom_range(1); spr_wdata = $urandom;
      step();
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule